// File: doc/BRIEF.md
# Multi-Mode Serial Receiver

This block receives serial characters in one of three modes and holds the last one in a data register with a set of status flags. Two modes are asynchronous. Each bit is sampled once in the middle of its 16 oversample ticks. The first of these modes is plain 8-bit reception with an optional parity bit. The second carries a ninth address/data bit in the slot the parity bit would use. The third mode is clocked synchronous: one data bit is shifted in on each rising edge of an external shift clock.

A completed character loads the data register and raises the ready flag. The point of completion depends on the mode: the stop-bit sample in the asynchronous modes, and the eighth shift-clock edge in synchronous mode. Error checks set sticky flags for overrun, framing and parity. The set of checks depends on the mode. Every completion also raises ready, and the data is marked invalid while any error flag is set. A CPU read strobe clears ready. A separate clear control clears the error flags. The interrupt request is the enable input ANDed with the OR of the ready flag and the error flags.

Top module: `serial_rx_unit`

## Requirements
- R1: In mode 0 or 1, a low level on the serial input starts a character. The start is accepted only if the input is still low 8 ticks later. Each later bit is sampled every 16 ticks, data LSB first. When the stop bit is sampled, the data register is loaded and `rdy_o` is set one clock later. A low pulse that has returned high by the mid-start sample loads nothing.
- R2: In mode 2 (and mode 3), one bit is shifted in, LSB first, on each rising edge of `sclk_i`. On the 8th edge the data register is loaded and `rdy_o` is set.
- R3: A one-cycle pulse on `rd_data_i` clears `rdy_o` and leaves the data register and the error flags unchanged.
- R4: In any mode, if a character completes while `rdy_o` is still set, `ore_o` is set and the data register takes the new character.
- R5: In mode 0 or 1, a stop bit sampled as 0 sets `fre_o`, together with `rdy_o`.
- R6: In mode 0 with `par_en_i`=1, the bit after the data is parity. `pe_o` is set when the count of ones in the data plus the parity bit is odd while `par_odd_i`=0, or even while `par_odd_i`=1.
- R7: In mode 1, the bit after the data is copied to `mp_bit_o`, and `pe_o` never sets.
- R8: In mode 2, neither `pe_o` nor `fre_o` ever sets.
- R9: A one-cycle pulse on `clr_err_i` clears `pe_o`, `ore_o` and `fre_o` and leaves `rdy_o` and the data unchanged.
- R10: `irq_o` equals `irq_en_i` AND (`rdy_o` OR any error flag). `data_ok_o` is high only when `rdy_o` is set and no error flag is set.
- R11: After reset, the data register, all flags and `mp_bit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 async normal, 1 async multiprocessor, 2/3 clocked synchronous |
| par_en_i | input | 1 | Parity bit present and checked (mode 0) |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| os_tick_i | input | 1 | Oversample enable, 16 per bit time |
| sclk_i | input | 1 | External shift clock (synchronous mode) |
| rxd_i | input | 1 | Serial data in |
| rd_data_i | input | 1 | CPU read strobe of the data register |
| clr_err_i | input | 1 | Clears the error flags |
| irq_en_i | input | 1 | Interrupt request enable |
| rx_data_o | output | 8 | Received data register |
| rdy_o | output | 1 | Receive data ready |
| pe_o | output | 1 | Parity error |
| ore_o | output | 1 | Overrun error |
| fre_o | output | 1 | Framing error |
| mp_bit_o | output | 1 | Ninth bit of the last multiprocessor character |
| data_ok_o | output | 1 | Ready with no error flag set |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A wrong sampling phase or a wrong bit counter in a core shows up in the next completed character. It is seen either as a wrong value in `rx_data_o` or as `rdy_o` rising in the wrong clock. The bench follows the expected flag state on every clock, so a completion that comes one cycle early or late is reported in that clock. A flag that is wrongly set or cleared, for example an error check that is active in a mode where it must be off, is seen at once on `irq_o` and `data_ok_o`, and it stays visible until the bench clears it.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    AS_IDLE, AS_START, AS_DATA, AS_EXTRA, AS_STOP
  } async_st_e;

  localparam logic [1:0] MODE_NORM = 2'd0;
  localparam logic [1:0] MODE_MP   = 2'd1;

  function automatic logic mode_is_sync(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/srx_async_core.sv
module srx_async_core
  import srx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              xbit_en_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              xbit_o,
  output logic              stop_bad_o
);
  localparam int CNT_W  = $clog2(OS_RATE);
  localparam int BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  HALF = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(OS_RATE - 1);
  localparam logic [BCNT_W-1:0] BLAST = BCNT_W'(DATA_W - 1);

  async_st_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BCNT_W-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= AS_IDLE;
      cnt_q      <= '0;
      bcnt_q     <= '0;
      data_o     <= '0;
      xbit_o     <= 1'b0;
      stop_bad_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        st_q <= AS_IDLE;
      end else if (tick_i) begin
        unique case (st_q)
          AS_IDLE: if (!rxd_i) begin
            st_q  <= AS_START;
            cnt_q <= '0;
          end
          AS_START: begin
            if (cnt_q == HALF) begin
              cnt_q  <= '0;
              bcnt_q <= '0;
              st_q   <= rxd_i ? AS_IDLE : AS_DATA; // reject glitch
            end else cnt_q <= cnt_q + 1'b1;
          end
          AS_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              data_o <= {rxd_i, data_o[DATA_W-1:1]};
              bcnt_q <= bcnt_q + 1'b1;
              if (bcnt_q == BLAST) st_q <= xbit_en_i ? AS_EXTRA : AS_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          AS_EXTRA: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              xbit_o <= rxd_i;
              st_q   <= AS_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          AS_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q      <= '0;
              stop_bad_o <= ~rxd_i;
              done_o     <= 1'b1;
              st_q       <= AS_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= AS_IDLE;
        endcase
      end
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_from_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> st_q == AS_IDLE);
endmodule

// File: rtl/srx_sync_core.sv
module srx_sync_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCNT_W-1:0] BLAST = BCNT_W'(DATA_W - 1);

  logic              sclk_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              rise;

  assign rise = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      bcnt_q <= '0;
      data_o <= '0;
      done_o <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      done_o <= 1'b0;
      if (!en_i) begin
        bcnt_q <= '0;
      end else if (rise) begin
        data_o <= {rxd_i, data_o[DATA_W-1:1]};
        if (bcnt_q == BLAST) begin
          bcnt_q <= '0;
          done_o <= 1'b1;
        end else bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assert_sync_done_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sclk_q);
  assert_sync_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              a_done_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_xbit_i,
  input  logic              a_stop_bad_i,
  input  logic              s_done_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              pe_o,
  output logic              ore_o,
  output logic              fre_o,
  output logic              mpb_o
);
  logic is_sync, is_mp, is_norm;
  logic done, pe_hit, fre_hit, ore_hit;

  assign is_sync = mode_is_sync(mode_i);
  assign is_mp   = (mode_i == MODE_MP);
  assign is_norm = (mode_i == MODE_NORM);
  assign done    = is_sync ? s_done_i : a_done_i;
  assign pe_hit  = is_norm & par_en_i & ((^a_data_i ^ a_xbit_i) != par_odd_i);
  assign fre_hit = ~is_sync & a_stop_bad_i;
  assign ore_hit = rdy_o & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      rdy_o  <= 1'b0;
      pe_o   <= 1'b0;
      ore_o  <= 1'b0;
      fre_o  <= 1'b0;
      mpb_o  <= 1'b0;
    end else if (done) begin
      data_o <= is_sync ? s_data_i : a_data_i;
      rdy_o  <= 1'b1;
      pe_o   <= pe_hit  | (pe_o  & ~clr_i);
      fre_o  <= fre_hit | (fre_o & ~clr_i);
      ore_o  <= ore_hit | (ore_o & ~clr_i);
      if (is_mp) mpb_o <= a_xbit_i;
    end else begin
      if (rd_i) rdy_o <= 1'b0;
      if (clr_i) begin
        pe_o  <= 1'b0;
        ore_o <= 1'b0;
        fre_o <= 1'b0;
      end
    end
  end

  assert_rd_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done |=> !rdy_o);
  assert_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && rdy_o && !rd_i |=> ore_o && rdy_o);
  assert_stop_bad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_done_i && !is_sync && a_stop_bad_i |=> fre_o && rdy_o);
  assert_mp_no_pe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && is_mp && !pe_o |=> !pe_o);
  assert_sync_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && is_sync && !pe_o && !fre_o |=> !pe_o && !fre_o);
  assert_clr_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !done |=> !pe_o && !ore_o && !fre_o);
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              os_tick_i,
  input  logic              sclk_i,
  input  logic              rxd_i,
  input  logic              rd_data_i,
  input  logic              clr_err_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rdy_o,
  output logic              pe_o,
  output logic              ore_o,
  output logic              fre_o,
  output logic              mp_bit_o,
  output logic              data_ok_o,
  output logic              irq_o
);
  logic              is_sync, xbit_en;
  logic              a_done, a_xbit, a_stop_bad, s_done;
  logic [DATA_W-1:0] a_data, s_data;
  logic              any_err;

  assign is_sync = mode_is_sync(mode_i);
  assign xbit_en = (mode_i == MODE_MP) | ((mode_i == MODE_NORM) & par_en_i);

  srx_async_core #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_async (
    .clk_i, .rst_ni, .en_i(~is_sync), .tick_i(os_tick_i), .rxd_i,
    .xbit_en_i(xbit_en), .done_o(a_done), .data_o(a_data),
    .xbit_o(a_xbit), .stop_bad_o(a_stop_bad)
  );

  srx_sync_core #(.DATA_W(DATA_W)) u_sync (
    .clk_i, .rst_ni, .en_i(is_sync), .sclk_i, .rxd_i,
    .done_o(s_done), .data_o(s_data)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i, .rst_ni, .mode_i, .par_en_i, .par_odd_i,
    .a_done_i(a_done), .a_data_i(a_data), .a_xbit_i(a_xbit),
    .a_stop_bad_i(a_stop_bad), .s_done_i(s_done), .s_data_i(s_data),
    .rd_i(rd_data_i), .clr_i(clr_err_i),
    .data_o(rx_data_o), .rdy_o, .pe_o, .ore_o, .fre_o, .mpb_o(mp_bit_o)
  );

  assign any_err   = pe_o | ore_o | fre_o;
  assign data_ok_o = rdy_o & ~any_err;
  assign irq_o     = irq_en_i & (rdy_o | any_err);

  assert_irq_needs_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i && (u_status.rdy_o || u_status.pe_o || u_status.ore_o || u_status.fre_o));
endmodule

// File: tb/tb_serial_rx_unit.sv
module tb_serial_rx_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       par_en = 0, par_odd = 0, tick = 1, sclk = 0, rxd = 1;
  logic       rd = 0, clr = 0, irq_en = 1;
  logic [7:0] rx_data;
  logic       rdy, pe, ore, fre, mpb, dok, irq;

  serial_rx_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .par_en_i(par_en),
    .par_odd_i(par_odd), .os_tick_i(tick), .sclk_i(sclk), .rxd_i(rxd),
    .rd_data_i(rd), .clr_err_i(clr), .irq_en_i(irq_en),
    .rx_data_o(rx_data), .rdy_o(rdy), .pe_o(pe), .ore_o(ore), .fre_o(fre),
    .mp_bit_o(mpb), .data_ok_o(dok), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R11";
  logic [7:0] m_data = 0;
  logic m_rdy = 0, m_pe = 0, m_ore = 0, m_fre = 0, m_mpb = 0;
  bit running = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference state
  always @(negedge clk) begin
    #1;
    if (running) begin
      chk(cur_req, "rx_data", rx_data, m_data);
      chk(cur_req, "rdy", rdy, m_rdy);
      chk(cur_req, "pe", pe, m_pe);
      chk(cur_req, "ore", ore, m_ore);
      chk(cur_req, "fre", fre, m_fre);
      chk(cur_req, "mp_bit", mpb, m_mpb);
      chk("R10", "data_ok", dok, m_rdy & ~(m_pe | m_ore | m_fre));
      chk("R10", "irq", irq, irq_en & (m_rdy | m_pe | m_ore | m_fre));
    end
  end

  task automatic mdl_done(logic [7:0] d, logic xb, logic stp);
    if (m_rdy) m_ore = 1;
    m_data = d;
    m_rdy  = 1;
    if (mode < 2 && !stp) m_fre = 1;
    if (mode == 0 && par_en && ((^d ^ xb) != par_odd)) m_pe = 1;
    if (mode == 1) m_mpb = xb;
  endtask

  task automatic send_async(logic [7:0] d, logic xb, logic stp);
    int js;
    js = 9 + ((mode == 1 || (mode == 0 && par_en)) ? 1 : 0);
    @(negedge clk) rxd = 0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    if (js == 10) begin
      rxd = xb;
      repeat (16) @(negedge clk);
    end
    rxd = stp;
    repeat (10) @(negedge clk);
    mdl_done(d, xb, stp);
    repeat (6) @(negedge clk);
    rxd = 1;
    repeat (24) @(negedge clk);
  endtask

  task automatic send_sync(logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) begin rxd = d[i]; sclk = 0; end
      @(negedge clk) sclk = 1;
    end
    @(negedge clk) sclk = 0;
    @(negedge clk) mdl_done(d, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1;
    @(negedge clk) begin rd = 0; m_rdy = 0; end
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1;
    @(negedge clk) begin clr = 0; m_pe = 0; m_ore = 0; m_fre = 0; end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    @(negedge clk); #2;
    chk("R11", "reset rdy/err", {rdy, pe, ore, fre, mpb}, 0);
    chk("R11", "reset data", rx_data, 0);

    cur_req = "R1";
    send_async(8'hA5, 0, 1);
    #2 chk("R1", "async data", rx_data, 8'hA5);
    cur_req = "R3";
    do_read();
    #2 chk("R3", "rdy after read", rdy, 0);
    chk("R3", "data kept", rx_data, 8'hA5);

    cur_req = "R4";
    send_async(8'h3C, 0, 1);
    send_async(8'h5A, 0, 1);
    #2 chk("R4", "overrun", ore, 1);
    chk("R4", "overwrite", rx_data, 8'h5A);
    chk("R10", "irq on err", irq, 1);
    cur_req = "R9";
    do_clear();
    #2 chk("R9", "ore cleared, rdy kept", {ore, rdy}, 2'b01);
    do_read();

    cur_req = "R5";
    send_async(8'h0F, 0, 0);
    #2 chk("R5", "framing", {fre, rdy}, 2'b11);
    chk("R10", "data_ok low", dok, 0);
    do_clear(); do_read();

    cur_req = "R6";
    par_en = 1; par_odd = 0;
    send_async(8'h03, 0, 1);
    #2 chk("R6", "even ok", pe, 0);
    do_read();
    send_async(8'h07, 0, 1);
    #2 chk("R6", "even bad", pe, 1);
    do_clear(); do_read();
    par_odd = 1;
    send_async(8'h07, 0, 1);
    #2 chk("R6", "odd ok", pe, 0);
    do_read();

    cur_req = "R7";
    mode = 2'd1;
    send_async(8'h81, 1, 1);
    #2 chk("R7", "mp bit 1", mpb, 1);
    chk("R7", "no pe", pe, 0);
    do_read();
    send_async(8'h22, 0, 1);
    #2 chk("R7", "mp bit 0", mpb, 0);
    do_read();

    cur_req = "R1";
    @(negedge clk) rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (40) @(negedge clk);
    #2 chk("R1", "glitch ignored", rdy, 0);

    cur_req = "R2";
    mode = 2'd2;
    repeat (4) @(negedge clk);
    send_sync(8'hC3);
    #2 chk("R2", "sync data", rx_data, 8'hC3);
    cur_req = "R4";
    send_sync(8'h11);
    #2 chk("R4", "sync overrun", ore, 1);
    cur_req = "R8";
    chk("R8", "sync no pe/fre", {pe, fre}, 0);
    do_clear();
    irq_en = 0;
    @(negedge clk); #2;
    chk("R10", "irq masked", irq, 0);
    do_read();
    send_sync(8'h00);
    #2 chk("R8", "sync zero no err", {pe, fre, ore}, 0);
    do_read();

    running = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule